// File: doc/BRIEF.md
# Open-Row Prefetch Engine for a DRAM Controller

This block lives inside a DRAM memory controller and turns demand reads that land in an already open row into short bursts of extra reads from that same row. The extra lines come back into small per-core holding buffers kept inside the controller; they never travel to the on-chip caches or over the network. A later demand read from the same core looks in its own holding buffer first and, on a match, is answered from there with no DRAM access.

The engine only acts when a demand read misses its holding buffer and finds the addressed bank open on the requested row. It stands aside when other demand requests are queued for that bank. It never crosses the end of the row, so no activate is ever caused. After a burst it can raise a precharge hint. A per-core usefulness score, built from buffer hits and from lines thrown out unused, picks how many lines each trigger fetches: none, half the maximum or the maximum.

The surrounding controller issues the actual DRAM commands. It reports the open state of the addressed bank alongside each demand and delivers returned prefetch data on the fill port.

Top module: `rowpf_engine`

## Requirements
- R1: A demand read (`dem_write`=0) whose bank, row and line equal a valid entry of its own core's buffer gives `hit_valid`=1 in the next cycle, with `hit_core` and `hit_data` from that entry. The entry is freed, so a repeat of the same read does not hit again.
- R2: A demand read that misses the buffers, with `bank_open`=1, `bank_row` equal to `dem_row` and `bank_waiting`=0, starts a burst to lines N+1, N+2, ... of the same core, bank and row in ascending order. The burst is sized by that core's current degree. The first command is on `pf_valid` in the cycle after the demand. Each later command follows the cycle after the previous one is accepted by `pf_ready`. No output is active out of reset.
- R3: No burst starts for a demand write, for a read whose row differs from `bank_row`, for a read with `bank_open`=0, or for a read that hits a buffer.
- R4: A qualifying read with `bank_waiting`=1 starts no burst.
- R5: A burst never passes line 63, the last line of the 64-line row: it is cut to 63-N lines. A trigger on line 63 issues nothing.
- R6: While `pf_valid`=1 and `pf_ready`=0, the command and its core, bank, row and line stay unchanged.
- R7: With `cfg_pre_en`=1, `pre_valid` pulses for one cycle, with `pre_bank` set to the burst's bank, in the cycle after the last command of a burst is accepted. With `cfg_pre_en`=0 no pulse is given.
- R8: A qualifying read that arrives while a burst is still in progress is dropped and never queued.
- R9: A demand write invalidates every matching entry in every core's buffer.
- R10: Fills into a core's buffer replace entries in fill order. Once the buffer is full, the next fill displaces the oldest fill.
- R11: Each core keeps a saturating score that starts at 128. A buffer hit adds one and an eviction of an unused entry subtracts one. After every 256 qualifying reads of that core (R2 conditions, any degree), the degree becomes 4 lines if score >= `cfg_hi`, 2 lines if score >= `cfg_lo`, and 0 otherwise, and the score returns to 128. The degree is 4 out of reset. The read that closes a window still uses the old degree.
- R12: A demand read is looked up only in the buffer of its own core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dem_valid | input | 1 | Demand request present |
| dem_write | input | 1 | Demand is a write |
| dem_core | input | 2 | Requesting core |
| dem_bank | input | 3 | Demand bank |
| dem_row | input | 14 | Demand row |
| dem_line | input | 6 | Cache line within the row |
| bank_open | input | 1 | Addressed bank has an open row |
| bank_row | input | 14 | Row open in the addressed bank |
| bank_waiting | input | 1 | Other demands are queued for the addressed bank |
| ret_valid | input | 1 | Returned prefetch line present |
| ret_core | input | 2 | Core whose buffer receives the line |
| ret_bank | input | 3 | Bank of the returned line |
| ret_row | input | 14 | Row of the returned line |
| ret_line | input | 6 | Line index of the returned line |
| ret_data | input | 64 | Returned line data |
| cfg_lo | input | 8 | Score threshold for half degree |
| cfg_hi | input | 8 | Score threshold for full degree |
| cfg_pre_en | input | 1 | Enable precharge hint after bursts |
| pf_ready | input | 1 | Controller accepts the prefetch command |
| pf_valid | output | 1 | Prefetch command present |
| pf_core | output | 2 | Core that owns the prefetch |
| pf_bank | output | 3 | Prefetch bank |
| pf_row | output | 14 | Prefetch row |
| pf_line | output | 6 | Prefetch line |
| pre_valid | output | 1 | Precharge hint pulse |
| pre_bank | output | 3 | Bank for the precharge hint |
| hit_valid | output | 1 | Demand served from a holding buffer |
| hit_core | output | 2 | Core of the served demand |
| hit_data | output | 64 | Data of the served line |

## Verification
The hardest state to reach is a change of degree. It only happens after 256 qualifying reads from one core, and it depends on the balance of hits and unused evictions that the surrounding traffic builds up. The stimulus dedicates one otherwise untouched core to this. It first forces sixteen unused evictions through the fill port and runs a full window at degree 4, which drops the degree to 0. A quiet window then lifts it to 2, and a window with three rounds of fill-then-hit traffic lifts it back to 4. The closing read of each window is checked to still use the old degree.

// File: rtl/rowpf_pkg.sv
package rowpf_pkg;

    typedef enum logic [1:0] {
        DEG_OFF  = 2'd0,
        DEG_HALF = 2'd1,
        DEG_FULL = 2'd2
    } pf_deg_e;

    // Number of lines one trigger may fetch for a given degree setting.
    function automatic int deg_lines(pf_deg_e d, int full);
        case (d)
            DEG_FULL: return full;
            DEG_HALF: return full / 2;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/rowpf_buffer.sv
// Per-core holding buffer: lookup-and-free, write invalidation, fill-order replacement.
module rowpf_buffer #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 23,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              evict_unused
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0] valid;
        logic [IDX_W-1:0]   ptr;
    } buf_st_t;

    buf_st_t           st_d, st_q;
    logic [ADDR_W-1:0] addr_d [ENTRIES];
    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [DATA_W-1:0] data_d [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [IDX_W-1:0]  hit_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && rd_valid && st_q.valid[i] && addr_q[i] == rd_addr) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_data = data_q[hit_idx];

        st_d   = st_q;
        addr_d = addr_q;
        data_d = data_q;
        evict_unused = 1'b0;

        if (hit) st_d.valid[hit_idx] = 1'b0;

        if (wr_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.valid[i] && addr_q[i] == wr_addr) st_d.valid[i] = 1'b0;
            end
        end

        if (fill_valid) begin
            evict_unused          = st_d.valid[st_q.ptr];
            st_d.valid[st_q.ptr]  = 1'b1;
            addr_d[st_q.ptr]      = fill_addr;
            data_d[st_q.ptr]      = fill_data;
            st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/rowpf_throttle.sv
// Per-core usefulness score and windowed degree selection.
module rowpf_throttle
    import rowpf_pkg::*;
#(
    parameter int SCORE_W = 8,
    parameter int WINDOW  = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               useful,
    input  logic               useless,
    input  logic               tick,
    input  logic [SCORE_W-1:0] cfg_lo,
    input  logic [SCORE_W-1:0] cfg_hi,
    output pf_deg_e            degree
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [SCORE_W-1:0] SCORE_MID = SCORE_W'(1 << (SCORE_W - 1));
    localparam logic [SCORE_W-1:0] SCORE_TOP = '1;
    localparam logic [WIN_W-1:0]   WIN_LAST  = WIN_W'(WINDOW - 1);

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic [WIN_W-1:0]   win;
        pf_deg_e            deg;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (useful && !useless && st_q.score != SCORE_TOP) st_d.score = st_q.score + 1'b1;
        if (useless && !useful && st_q.score != '0)        st_d.score = st_q.score - 1'b1;

        if (tick) begin
            if (st_q.win == WIN_LAST) begin
                st_d.win = '0;
                if (st_d.score >= cfg_hi)      st_d.deg = DEG_FULL;
                else if (st_d.score >= cfg_lo) st_d.deg = DEG_HALF;
                else                           st_d.deg = DEG_OFF;
                st_d.score = SCORE_MID;
            end else begin
                st_d.win = st_q.win + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{score: SCORE_MID, win: '0, deg: DEG_FULL};
        else        st_q <= st_d;
    end

    assign degree = st_q.deg;

endmodule

// File: rtl/rowpf_burst.sv
// Walks one prefetch burst through consecutive lines and raises the precharge hint.
module rowpf_burst #(
    parameter int CORE_W = 2,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int LINE_W = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CORE_W-1:0] st_core,
    input  logic [BANK_W-1:0] st_bank,
    input  logic [ROW_W-1:0]  st_row,
    input  logic [LINE_W-1:0] st_line,
    input  logic [CNT_W-1:0]  st_cnt,
    input  logic              pre_en,
    input  logic              pf_ready,
    output logic              busy,
    output logic              pf_valid,
    output logic [CORE_W-1:0] pf_core,
    output logic [BANK_W-1:0] pf_bank,
    output logic [ROW_W-1:0]  pf_row,
    output logic [LINE_W-1:0] pf_line,
    output logic              pre_valid,
    output logic [BANK_W-1:0] pre_bank
);
    typedef struct packed {
        logic              busy;
        logic              pre;
        logic [CORE_W-1:0] core;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  left;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = 1'b0;
        if (st_q.busy && pf_ready) begin
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.pre  = pre_en;
            end else begin
                st_d.line = st_q.line + 1'b1;
                st_d.left = st_q.left - 1'b1;
            end
        end
        if (start && !st_q.busy && st_cnt != '0) begin
            st_d.busy = 1'b1;
            st_d.core = st_core;
            st_d.bank = st_bank;
            st_d.row  = st_row;
            st_d.line = st_line;
            st_d.left = st_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign pf_valid  = st_q.busy;
    assign pf_core   = st_q.core;
    assign pf_bank   = st_q.bank;
    assign pf_row    = st_q.row;
    assign pf_line   = st_q.line;
    assign pre_valid = st_q.pre;
    assign pre_bank  = st_q.bank;

endmodule

// File: rtl/rowpf_engine.sv
module rowpf_engine
    import rowpf_pkg::*;
#(
    parameter int N_CORES    = 4,
    parameter int PF_ENTRIES = 4,
    parameter int BANK_W     = 3,
    parameter int ROW_W      = 14,
    parameter int ROW_LINES  = 64,
    parameter int DATA_W     = 64,
    parameter int SCORE_W    = 8,
    parameter int WINDOW     = 256,
    parameter int MAX_DEG    = 4,
    localparam int CORE_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int LINE_W    = $clog2(ROW_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dem_valid,
    input  logic               dem_write,
    input  logic [CORE_W-1:0]  dem_core,
    input  logic [BANK_W-1:0]  dem_bank,
    input  logic [ROW_W-1:0]   dem_row,
    input  logic [LINE_W-1:0]  dem_line,
    input  logic               bank_open,
    input  logic [ROW_W-1:0]   bank_row,
    input  logic               bank_waiting,
    input  logic               ret_valid,
    input  logic [CORE_W-1:0]  ret_core,
    input  logic [BANK_W-1:0]  ret_bank,
    input  logic [ROW_W-1:0]   ret_row,
    input  logic [LINE_W-1:0]  ret_line,
    input  logic [DATA_W-1:0]  ret_data,
    input  logic [SCORE_W-1:0] cfg_lo,
    input  logic [SCORE_W-1:0] cfg_hi,
    input  logic               cfg_pre_en,
    input  logic               pf_ready,
    output logic               pf_valid,
    output logic [CORE_W-1:0]  pf_core,
    output logic [BANK_W-1:0]  pf_bank,
    output logic [ROW_W-1:0]   pf_row,
    output logic [LINE_W-1:0]  pf_line,
    output logic               pre_valid,
    output logic [BANK_W-1:0]  pre_bank,
    output logic               hit_valid,
    output logic [CORE_W-1:0]  hit_core,
    output logic [DATA_W-1:0]  hit_data
);
    localparam int ADDR_W = BANK_W + ROW_W + LINE_W;
    localparam int CNT_W  = $clog2(MAX_DEG + 1);

    typedef struct packed {
        logic              v;
        logic [CORE_W-1:0] core;
        logic [DATA_W-1:0] data;
    } hit_t;

    hit_t hit_d, hit_q;

    logic [ADDR_W-1:0]  dem_addr, ret_addr;
    logic [N_CORES-1:0] hit_vec, evict_vec;
    logic [DATA_W-1:0]  hit_data_arr [N_CORES];
    pf_deg_e            deg_arr [N_CORES];

    logic               any_hit, row_hit, qualify, start, pf_busy;
    logic [CNT_W-1:0]   st_cnt;
    logic [LINE_W-1:0]  st_line;
    int                 want, room, take;

    assign dem_addr = {dem_bank, dem_row, dem_line};
    assign ret_addr = {ret_bank, ret_row, ret_line};

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic rd_sel, fill_sel, tick_sel;
        assign rd_sel   = dem_valid && !dem_write && dem_core == CORE_W'(c);
        assign fill_sel = ret_valid && ret_core == CORE_W'(c);
        assign tick_sel = qualify && dem_core == CORE_W'(c);

        rowpf_buffer #(
            .ENTRIES(PF_ENTRIES),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_buf (
            .clk         (clk),
            .rst_n       (rst_n),
            .rd_valid    (rd_sel),
            .rd_addr     (dem_addr),
            .hit         (hit_vec[c]),
            .hit_data    (hit_data_arr[c]),
            .wr_valid    (dem_valid && dem_write),
            .wr_addr     (dem_addr),
            .fill_valid  (fill_sel),
            .fill_addr   (ret_addr),
            .fill_data   (ret_data),
            .evict_unused(evict_vec[c])
        );

        rowpf_throttle #(
            .SCORE_W(SCORE_W),
            .WINDOW (WINDOW)
        ) u_thr (
            .clk    (clk),
            .rst_n  (rst_n),
            .useful (hit_vec[c]),
            .useless(evict_vec[c]),
            .tick   (tick_sel),
            .cfg_lo (cfg_lo),
            .cfg_hi (cfg_hi),
            .degree (deg_arr[c])
        );
    end

    always_comb begin
        any_hit = |hit_vec;
        row_hit = bank_open && bank_row == dem_row;
        qualify = dem_valid && !dem_write && !any_hit && row_hit && !bank_waiting && !pf_busy;

        want = deg_lines(deg_arr[dem_core], MAX_DEG);
        room = (ROW_LINES - 1) - int'(dem_line);
        take = (want < room) ? want : room;
        st_cnt  = CNT_W'(take);
        st_line = dem_line + 1'b1;
        start   = qualify && take > 0;

        hit_d      = '0;
        hit_d.v    = any_hit;
        hit_d.core = dem_core;
        hit_d.data = hit_data_arr[dem_core];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit_d;
    end

    rowpf_burst #(
        .CORE_W(CORE_W),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .LINE_W(LINE_W),
        .CNT_W (CNT_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st_core  (dem_core),
        .st_bank  (dem_bank),
        .st_row   (dem_row),
        .st_line  (st_line),
        .st_cnt   (st_cnt),
        .pre_en   (cfg_pre_en),
        .pf_ready (pf_ready),
        .busy     (pf_busy),
        .pf_valid (pf_valid),
        .pf_core  (pf_core),
        .pf_bank  (pf_bank),
        .pf_row   (pf_row),
        .pf_line  (pf_line),
        .pre_valid(pre_valid),
        .pre_bank (pre_bank)
    );

    assign hit_valid = hit_q.v;
    assign hit_core  = hit_q.core;
    assign hit_data  = hit_q.data;

endmodule

// File: rtl/rowpf_checker.sv
module rowpf_checker #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int LINE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dem_valid,
    input logic              dem_write,
    input logic              bank_waiting,
    input logic              pf_ready,
    input logic              pf_valid,
    input logic [BANK_W-1:0] pf_bank,
    input logic [ROW_W-1:0]  pf_row,
    input logic [LINE_W-1:0] pf_line,
    input logic              pre_valid,
    input logic              hit_valid
);
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_line) && $stable(pf_row) && $stable(pf_bank));

    a_r5_never_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_line != '0);

    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> !pf_valid || pf_line == $past(pf_line) + 1'b1);

    a_r7_pre_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        pre_valid |-> !pf_valid);

    a_r7_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        pre_valid |=> !pre_valid);

    a_r4_waiting_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && !dem_write && bank_waiting && !pf_valid |=> !pf_valid);

    a_r9_write_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dem_write |=> !hit_valid);
endmodule

bind rowpf_engine rowpf_checker #(
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dem_valid   (dem_valid),
    .dem_write   (dem_write),
    .bank_waiting(bank_waiting),
    .pf_ready    (pf_ready),
    .pf_valid    (pf_valid),
    .pf_bank     (pf_bank),
    .pf_row      (pf_row),
    .pf_line     (pf_line),
    .pre_valid   (pre_valid),
    .hit_valid   (hit_valid)
);

// File: tb/tb_rowpf_engine.sv
module tb_rowpf_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dem_valid = 0, dem_write = 0;
    logic [1:0]  dem_core = 0;
    logic [2:0]  dem_bank = 0;
    logic [13:0] dem_row = 0;
    logic [5:0]  dem_line = 0;
    logic        bank_open = 0;
    logic [13:0] bank_row = 0;
    logic        bank_waiting = 0;
    logic        ret_valid = 0;
    logic [1:0]  ret_core = 0;
    logic [2:0]  ret_bank = 0;
    logic [13:0] ret_row = 0;
    logic [5:0]  ret_line = 0;
    logic [63:0] ret_data = 0;
    logic [7:0]  cfg_lo = 8'd120, cfg_hi = 8'd136;
    logic        cfg_pre_en = 1'b1;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [1:0]  pf_core;
    logic [2:0]  pf_bank;
    logic [13:0] pf_row;
    logic [5:0]  pf_line;
    logic        pre_valid;
    logic [2:0]  pre_bank;
    logic        hit_valid;
    logic [1:0]  hit_core;
    logic [63:0] hit_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [24:0] pf_q[$];
    string       pf_rq[$];
    logic [65:0] hit_q[$];
    string       hit_rq[$];
    logic [2:0]  pre_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rowpf_engine dut (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input string what, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pf_valid && pf_ready) begin
                if (pf_q.size() == 0) begin
                    check(0, "R2", "unexpected prefetch", {41'd0, pf_core, pf_bank, pf_row, pf_line}, 66'd0);
                end else begin
                    logic [24:0] e;
                    string r;
                    e = pf_q.pop_front();
                    r = pf_rq.pop_front();
                    check({pf_core, pf_bank, pf_row, pf_line} === e, r, "prefetch command",
                          {41'd0, pf_core, pf_bank, pf_row, pf_line}, {41'd0, e});
                end
            end
            if (hit_valid) begin
                if (hit_q.size() == 0) begin
                    check(0, "R1", "unexpected buffer hit", {hit_core, hit_data}, 66'd0);
                end else begin
                    logic [65:0] e;
                    string r;
                    e = hit_q.pop_front();
                    r = hit_rq.pop_front();
                    check({hit_core, hit_data} === e, r, "buffer hit", {hit_core, hit_data}, e);
                end
            end
            if (pre_valid) begin
                if (pre_q.size() == 0) begin
                    check(0, "R7", "unexpected precharge hint", {63'd0, pre_bank}, 66'd0);
                end else begin
                    logic [2:0] e;
                    e = pre_q.pop_front();
                    check(pre_bank === e, "R7", "precharge bank", {63'd0, pre_bank}, {63'd0, e});
                end
            end
        end
    end

    task automatic dread(input logic [1:0] c, input logic [2:0] b, input logic [13:0] r, input logic [5:0] l,
                         input bit open, input logic [13:0] orow, input bit waiting, input bit wr);
        dem_valid = 1; dem_write = wr; dem_core = c; dem_bank = b; dem_row = r; dem_line = l;
        bank_open = open; bank_row = orow; bank_waiting = waiting;
        tick();
        dem_valid = 0; dem_write = 0; bank_open = 0; bank_waiting = 0;
    endtask

    // Driver: pushes the expected burst, then drives the triggering read on an open matching row.
    task automatic trig(input logic [1:0] c, input logic [2:0] b, input logic [13:0] r, input logic [5:0] l,
                        input int n, input string req);
        int lim;
        lim = (n < 63 - int'(l)) ? n : 63 - int'(l);
        for (int k = 1; k <= lim; k++) begin
            pf_q.push_back({c, b, r, 6'(int'(l) + k)});
            pf_rq.push_back(req);
        end
        if (lim > 0 && cfg_pre_en) pre_q.push_back(b);
        dread(c, b, r, l, 1, r, 0, 0);
        repeat (lim + 2) tick();
    endtask

    task automatic fill(input logic [1:0] c, input logic [2:0] b, input logic [13:0] r, input logic [5:0] l);
        ret_valid = 1; ret_core = c; ret_bank = b; ret_row = r; ret_line = l;
        ret_data = {32'hDA7A0000, 9'd0, b, r, l};
        tick();
        ret_valid = 0;
    endtask

    task automatic expect_hit(input logic [1:0] c, input logic [2:0] b, input logic [13:0] r, input logic [5:0] l,
                              input string req);
        hit_q.push_back({c, 32'hDA7A0000, 9'd0, b, r, l});
        hit_rq.push_back(req);
    endtask

    task automatic drained(input string req);
        repeat (3) tick();
        check(pf_q.size() == 0 && hit_q.size() == 0 && pre_q.size() == 0 && !pf_valid, req,
              "expected traffic not all seen", {pf_q.size(), hit_q.size(), pre_q.size()}, 66'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // Reset state (R2: no output active out of reset)
        check(!pf_valid && !pre_valid && !hit_valid, "R2", "outputs after reset",
              {63'd0, pf_valid, pre_valid, hit_valid}, 66'd0);

        // R2: basic burst of four lines after a row hit
        trig(0, 1, 14'h055, 10, 4, "R2");
        drained("R2");

        // R3: row mismatch, closed bank, write
        dread(0, 1, 14'h055, 10, 1, 14'h056, 0, 0);
        dread(0, 1, 14'h055, 10, 0, 14'h055, 0, 0);
        dread(0, 1, 14'h055, 10, 1, 14'h055, 0, 1);
        drained("R3");

        // R4: demand waiting for the bank
        dread(0, 2, 14'h100, 3, 1, 14'h100, 1, 0);
        drained("R4");

        // R5: row boundary clipping
        trig(0, 2, 14'h101, 61, 4, "R5");
        trig(0, 2, 14'h101, 63, 4, "R5");
        drained("R5");

        // R6 and R8: stall mid burst, second trigger dropped
        for (int k = 1; k <= 4; k++) begin
            pf_q.push_back({2'd0, 3'd3, 14'h200, 6'(20 + k)});
            pf_rq.push_back("R6");
        end
        pre_q.push_back(3'd3);
        dread(0, 3, 14'h200, 20, 1, 14'h200, 0, 0);
        pf_ready = 0;
        dread(1, 4, 14'h210, 40, 1, 14'h210, 0, 0);
        repeat (2) tick();
        check(pf_valid && pf_line == 6'd21 && pf_row == 14'h200, "R6", "held command",
              {51'd0, pf_valid, pf_row, pf_line}, {51'd1, 14'h200, 6'd21});
        pf_ready = 1;
        repeat (6) tick();
        drained("R8");

        // R7: precharge hint disabled
        cfg_pre_en = 0;
        trig(0, 4, 14'h300, 0, 4, "R7");
        cfg_pre_en = 1;
        drained("R7");

        // R1: buffer hit, entry freed, no trigger on a hit even with the row open
        fill(2, 2, 14'h007, 5);
        expect_hit(2, 2, 14'h007, 5, "R1");
        dread(2, 2, 14'h007, 5, 1, 14'h007, 0, 0);
        repeat (2) tick();
        dread(2, 2, 14'h007, 5, 0, 14'h000, 0, 0);
        drained("R1");

        // R12: lookup only in own core's buffer
        fill(1, 1, 14'h020, 9);
        dread(3, 1, 14'h020, 9, 0, 14'h000, 0, 0);
        expect_hit(1, 1, 14'h020, 9, "R12");
        dread(1, 1, 14'h020, 9, 0, 14'h000, 0, 0);
        drained("R12");

        // R9: write invalidates in every buffer
        fill(0, 6, 14'h030, 2);
        fill(3, 6, 14'h030, 2);
        dread(2, 6, 14'h030, 2, 0, 14'h000, 0, 1);
        dread(0, 6, 14'h030, 2, 0, 14'h000, 0, 0);
        dread(3, 6, 14'h030, 2, 0, 14'h000, 0, 0);
        drained("R9");

        // R10: fill-order replacement on core 1
        for (int k = 0; k < 5; k++) fill(1, 7, 14'h040, 6'(k));
        dread(1, 7, 14'h040, 0, 0, 14'h000, 0, 0);
        expect_hit(1, 7, 14'h040, 1, "R10");
        dread(1, 7, 14'h040, 1, 0, 14'h000, 0, 0);
        expect_hit(1, 7, 14'h040, 4, "R10");
        dread(1, 7, 14'h040, 4, 0, 14'h000, 0, 0);
        drained("R10");

        // R11: throttle on core 3. Sixteen unused evictions: score 112.
        for (int k = 0; k < 20; k++) fill(3, 5, 14'h050, 6'(k));
        for (int k = 0; k < 256; k++) trig(3, 5, 14'h300, 0, 4, "R11");
        drained("R11");
        // Degree now 0 for a whole window; score 128 at its end gives half degree.
        for (int k = 0; k < 256; k++) trig(3, 5, 14'h300, 0, 0, "R11");
        drained("R11");
        // Half degree window with net +8 score.
        for (int k = 0; k < 256; k++) begin
            trig(3, 5, 14'h300, 0, 2, "R11");
            if (k == 100) begin
                for (int rnd = 0; rnd < 3; rnd++) begin
                    for (int e = 0; e < 4; e++) fill(3, 6, 14'h060, 6'(e));
                    for (int e = 0; e < 4; e++) begin
                        expect_hit(3, 6, 14'h060, 6'(e), "R11");
                        dread(3, 6, 14'h060, 6'(e), 0, 14'h000, 0, 0);
                    end
                end
            end
        end
        drained("R11");
        trig(3, 5, 14'h300, 0, 4, "R11");
        drained("R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule